// File: doc/BRIEF.md
# Audio ADC Receive FIFO Controller

This block takes 20-bit samples from an audio ADC digital front end and stores them in a 128-entry receive FIFO. A processor or DMA engine drains the FIFO with a pop strobe. Each popped sample is presented as a 32-bit word. The word is either left-justified with zero fill or right-justified with sign extension, at 20-bit or 16-bit resolution.

The FIFO accepts samples only while the ADC enable bit is set. An optional start-up hold can also keep the FIFO closed for a few milliseconds after that bit rises. The block raises a DMA request and a data-available interrupt when the FIFO level is strictly above a programmed trigger level. A sample that arrives while the FIFO is full is dropped, and a sticky overrun flag is set. That flag can also drive the interrupt.

The sample input follows valid/ready naming, but the front end never waits. `s_ready` shows whether a sample offered in the current cycle will be stored. A sample offered with `s_ready` low is discarded. If the FIFO is open but full, that sample also sets the overrun flag.

The register port has two addresses:
- Address 0 is the control word.
- Address 1 is the status word. Bit 0 is the overrun flag, which is cleared by writing 1 to it. Bits 15:8 hold the FIFO level.

Top module: `adc_rx_fifo_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000_0400 (trigger level 0x40, all other fields 0). The status word reads 0, and `irq`, `drq`, `s_ready` and `rd_data` are all 0.
- R2: While control bit 28 (ADC enable) is 0, no offered sample is stored and the FIFO level does not change.
- R3: Control bit 25 enables the start-up hold, and bits 27:26 select its length: code 0, 1, 2 or 3 gives 5, 10, 20 or 30 ms. The hold starts at the write that sets bit 28 from 0 to 1. For that many milliseconds of clock ticks after that write, `s_ready` is low and samples are discarded. From the next cycle on, samples are stored.
- R4: Stored samples pop out in arrival order. The status level (bits 15:8) counts stored entries.
- R5: With control bit 16 = 1 (20-bit resolution), the read word depends on control bit 24. When bit 24 = 0, it is the 20 sample bits followed by 12 zero bits. When bit 24 = 1, it is the 20 bits sign-extended from sample bit 19.
- R6: With control bit 16 = 0 (16-bit resolution), only sample bits 19:4 are used. When bit 24 = 0, they sit in bits 31:16 with zeros below. When bit 24 = 1, they are sign-extended from sample bit 19.
- R7: `drq` is 1 exactly when control bit 3 is set and the level is strictly greater than the trigger level in control bits 11:4.
- R8: The data-available part of `irq` is the same threshold condition, gated by control bit 2.
- R9: A sample offered while the FIFO is open and full (128 entries) is dropped and sets status bit 0. The flag stays set until a 1 is written to status bit 0. With control bit 1 set, the flag drives `irq`.
- R10: Writing 1 to control bit 0 empties the FIFO at that write. Control bit 0 always reads back 0.
- R11: While the FIFO is empty, `rd_data` is 0, and a pop leaves the level unchanged.
- R12: `s_ready` is 1 exactly when the FIFO is enabled, not in its start-up hold, and not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Sample offered this cycle |
| s_ready | output | 1 | Offered sample will be stored |
| s_data | input | 20 | ADC sample |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pop | input | 1 | Remove the head sample |
| rd_data | output | 32 | Formatted head sample, 0 when empty |
| irq | output | 1 | Interrupt |
| drq | output | 1 | DMA request |

## Verification
A sample stored at a clock edge is visible in the level, `drq`, `irq` and `rd_data` right after that edge, because all of these are combinational from registers. The bench therefore drives at a falling edge and reads results one falling edge later.

A register write takes effect at the next rising edge. The start-up hold is checked by counting edges exactly: valid is held high from the edge after the enable write. After N ms × ticks-per-ms + 5 edges, exactly five samples must be stored.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;

  typedef struct packed {
    logic       en;
    logic [1:0] dly_code;
    logic       dly_on;
    logic       sign_mode;
    logic       res_full;
    logic [7:0] trig;
    logic       drq_en;
    logic       dav_en;
    logic       ovr_en;
  } rx_ctrl_t;

  localparam logic [31:0] CTRL_RESET = 32'h0000_0400;

  function automatic int unsigned hold_ms(input logic [1:0] code);
    case (code)
      2'd0:    return 5;
      2'd1:    return 10;
      2'd2:    return 20;
      default: return 30;
    endcase
  endfunction

  function automatic rx_ctrl_t ctrl_from_word(input logic [31:0] w);
    rx_ctrl_t c;
    c.en        = w[28];
    c.dly_code  = w[27:26];
    c.dly_on    = w[25];
    c.sign_mode = w[24];
    c.res_full  = w[16];
    c.trig      = w[11:4];
    c.drq_en    = w[3];
    c.dav_en    = w[2];
    c.ovr_en    = w[1];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input rx_ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[28]    = c.en;
    w[27:26] = c.dly_code;
    w[25]    = c.dly_on;
    w[24]    = c.sign_mode;
    w[16]    = c.res_full;
    w[11:4]  = c.trig;
    w[3]     = c.drq_en;
    w[2]     = c.dav_en;
    w[1]     = c.ovr_en;
    return w;
  endfunction

endpackage

// File: rtl/adc_rx_store.sv
module adc_rx_store #(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 128,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [LW-1:0]     level,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/adc_rx_start_gate.sv
module adc_rx_start_gate
  import adc_rx_pkg::*;
#(
  parameter int TICKS_PER_MS = 24000,
  parameter int MS_W         = 5,
  localparam int PW          = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dly_on,
  input  logic [1:0] code,
  output logic       hold
);
  logic [PW-1:0]   pre;
  logic [MS_W-1:0] ms_left;
  logic            tick;

  assign tick = (pre == PW'(TICKS_PER_MS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= 1'b0;
      pre     <= '0;
      ms_left <= '0;
    end else if (start) begin
      hold    <= dly_on;
      pre     <= '0;
      ms_left <= MS_W'(hold_ms(code));
    end else if (hold) begin
      if (tick) begin
        pre     <= '0;
        ms_left <= ms_left - 1'b1;
        if (ms_left == MS_W'(1)) hold <= 1'b0;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_rx_fmt.sv
module adc_rx_fmt #(
  parameter int IN_W     = 20,
  parameter int NARROW_W = 16,
  parameter int OUT_W    = 32
) (
  input  logic [IN_W-1:0]  sample,
  input  logic             present,
  input  logic             res_full,
  input  logic             sign_mode,
  output logic [OUT_W-1:0] word
);
  logic [NARROW_W-1:0] narrow;
  logic [OUT_W-1:0]    full_left, full_right, nar_left, nar_right;

  assign narrow     = sample[IN_W-1 -: NARROW_W];
  assign full_left  = {sample, {(OUT_W - IN_W){1'b0}}};
  assign full_right = {{(OUT_W - IN_W){sample[IN_W-1]}}, sample};
  assign nar_left   = {narrow, {(OUT_W - NARROW_W){1'b0}}};
  assign nar_right  = {{(OUT_W - NARROW_W){narrow[NARROW_W-1]}}, narrow};

  always_comb begin
    if (!present)      word = '0;
    else if (res_full) word = sign_mode ? full_right : full_left;
    else               word = sign_mode ? nar_right : nar_left;
  end
endmodule

// File: rtl/adc_rx_fifo_ctrl.sv
module adc_rx_fifo_ctrl
  import adc_rx_pkg::*;
#(
  parameter int CLK_HZ   = 24_000_000,
  parameter int DEPTH    = 128,
  parameter int SAMPLE_W = 20,
  parameter int NARROW_W = 16,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                reg_we,
  input  logic                reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                pop,
  output logic [WORD_W-1:0]   rd_data,
  output logic                irq,
  output logic                drq
);
  localparam int TICKS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int CMP_W = (LVL_W > 8) ? LVL_W : 8;

  rx_ctrl_t            ctrl, ctrl_nxt;
  logic                wr_ctrl, wr_stat, flush_pulse, start_pulse;
  logic                hold, gate_open, full, empty, push;
  logic                ovr, ovr_set, ovr_clr, above;
  logic [LVL_W-1:0]    level;
  logic [SAMPLE_W-1:0] head;
  logic [31:0]         stat_word;

  assign wr_ctrl     = reg_we && !reg_addr;
  assign wr_stat     = reg_we && reg_addr;
  assign ctrl_nxt    = ctrl_from_word(reg_wdata);
  assign flush_pulse = wr_ctrl && reg_wdata[0];
  assign start_pulse = wr_ctrl && ctrl_nxt.en && !ctrl.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= ctrl_from_word(CTRL_RESET);
    else if (wr_ctrl) ctrl <= ctrl_nxt;
  end

  adc_rx_start_gate #(.TICKS_PER_MS(TICKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .start(start_pulse),
    .dly_on(ctrl_nxt.dly_on), .code(ctrl_nxt.dly_code), .hold(hold)
  );

  assign gate_open = ctrl.en && !hold;
  assign s_ready   = gate_open && !full;
  assign push      = s_valid && s_ready;
  assign ovr_set   = s_valid && gate_open && full;
  assign ovr_clr   = wr_stat && reg_wdata[0];

  adc_rx_store #(.DATA_W(SAMPLE_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_pulse), .push(push), .pop(pop),
    .wdata(s_data), .head(head), .level(level), .full(full), .empty(empty)
  );

  adc_rx_fmt #(.IN_W(SAMPLE_W), .NARROW_W(NARROW_W), .OUT_W(WORD_W)) u_fmt (
    .sample(head), .present(!empty), .res_full(ctrl.res_full),
    .sign_mode(ctrl.sign_mode), .word(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr <= 1'b0;
    else if (ovr_set) ovr <= 1'b1;
    else if (ovr_clr) ovr <= 1'b0;
  end

  assign above = CMP_W'(level) > CMP_W'(ctrl.trig);
  assign drq   = ctrl.drq_en && above;
  assign irq   = (ctrl.dav_en && above) || (ctrl.ovr_en && ovr);

  always_comb begin
    stat_word              = '0;
    stat_word[0]           = ovr;
    stat_word[8 +: LVL_W]  = level;
  end

  assign reg_rdata = reg_addr ? stat_word : ctrl_to_word(ctrl);
endmodule

// File: rtl/adc_rx_chk.sv
module adc_rx_chk #(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          pop,
  input logic          flush,
  input logic          start,
  input logic          dly_on,
  input logic          en,
  input logic          empty,
  input logic          ovr,
  input logic          ovr_clr,
  input logic [LW-1:0] level,
  input logic [31:0]   rd_data
);
  a_r2_disabled_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> level <= $past(level));

  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dly_on) |=> !s_ready);

  a_r12_accept_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !pop && !flush) |=> level == LW'($past(level) + 1'b1));

  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0);

  a_r11_pop_empty_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !s_valid && !flush) |=> $stable(level));

  a_r11_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> rd_data == '0);
endmodule

bind adc_rx_fifo_ctrl adc_rx_chk #(.LW(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .pop(pop),
  .flush(flush_pulse), .start(start_pulse), .dly_on(ctrl_nxt.dly_on),
  .en(ctrl.en), .empty(empty), .ovr(ovr), .ovr_clr(ovr_clr), .level(level),
  .rd_data(rd_data)
);

// File: tb/tb_adc_rx_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_adc_rx_fifo_ctrl;
  localparam int TPM = 4;
  localparam logic [31:0] EN = 32'h1000_0000, DLY = 32'h0200_0000, MODE = 32'h0100_0000,
    RES = 32'h0001_0000, DRQ = 32'h8, DAV = 32'h4, OVE = 32'h2;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_ready, reg_we = 0, reg_addr = 0, pop = 0, irq, drq;
  logic [19:0] s_data = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, rd_data;

  always #2.5 clk = ~clk;

  adc_rx_fifo_ctrl #(.CLK_HZ(TPM * 1000)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [19:0] q[$];
  logic [31:0] ctl = 32'h400;
  logic        ovr_m = 0;

  function automatic logic [31:0] exp_word(logic [19:0] d, logic [31:0] c);
    if (c[16]) return c[24] ? {{12{d[19]}}, d} : {d, 12'h0};
    return c[24] ? {{16{d[19]}}, d[19:4]} : {d[19:4], 16'h0};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    if (!a) begin ctl = d & ~32'h1; if (d[0]) q.delete(); end
    else if (d[0]) ovr_m = 0;
  endtask

  task automatic rd(logic a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic push(logic [19:0] d);
    @(negedge clk); s_valid = 1; s_data = d;
    if (ctl[28]) begin
      if (q.size() < 128) q.push_back(d); else ovr_m = 1;
    end
    @(negedge clk); s_valid = 0;
  endtask

  task automatic pop_chk(string tag);
    @(negedge clk);
    chk(tag, rd_data, (q.size() != 0) ? exp_word(q[0], ctl) : 32'h0);
    pop = 1;
    @(negedge clk); pop = 0;
    if (q.size() != 0) void'(q.pop_front());
  endtask

  task automatic chk_state(string tag);
    logic [31:0] v;
    rd(1, v);
    chk({tag, " R4 level"}, {24'h0, v[15:8]}, q.size());
    chk({tag, " R9 ovr"}, {31'h0, v[0]}, {31'h0, ovr_m});
    chk({tag, " R7 drq"}, {31'h0, drq}, {31'h0, ctl[3] && q.size() > ctl[11:4]});
    chk({tag, " R8 irq"}, {31'h0, irq},
        {31'h0, (ctl[2] && q.size() > ctl[11:4]) || (ctl[1] && ovr_m)});
  endtask

  task automatic delay_run(logic [1:0] code, int ms);
    logic [31:0] v;
    wr(0, 32'h400);
    wr(0, 32'h401);
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 32'h400 | EN | DLY | (32'(code) << 26);
    @(negedge clk); reg_we = 0; s_valid = 1; s_data = 20'h1;
    ctl = reg_wdata;
    chk("R3 ready low in hold", {31'h0, s_ready}, 0);
    repeat (ms * TPM + 5) @(negedge clk);
    s_valid = 0;
    rd(1, v);
    chk($sformatf("R3 code %0d stored", code), {24'h0, v[15:8]}, 5);
    wr(0, ctl | 32'h1);
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); chk("R1 ctrl reset", v, 32'h0000_0400);
    rd(1, v); chk("R1 status reset", v, 0);
    chk("R1 irq", {31'h0, irq}, 0);
    chk("R1 drq", {31'h0, drq}, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 s_ready", {31'h0, s_ready}, 0);
    // R2 disabled
    push(20'h12345); push(20'h54321);
    chk_state("R2 disabled");
    // enable, no hold
    wr(0, 32'h400 | EN);
    chk("R12 ready when enabled", {31'h0, s_ready}, 1);
    // R5/R6 formats
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        wr(0, 32'h400 | EN | (m[0] ? RES : 0) | (m[1] ? MODE : 0));
        push(s ? 20'h8_1234 : 20'h7_ABCD);
        pop_chk(m[0] ? "R5 format 20-bit" : "R6 format 16-bit");
      end
    end
    // R7/R8 strict threshold
    wr(0, EN | RES | DRQ | DAV | (32'd2 << 4));
    push(20'h1); push(20'h2);
    chk_state("R7 at trigger");
    push(20'h3);
    chk_state("R7 above trigger");
    wr(0, EN | RES | DRQ | (32'd2 << 4));
    chk_state("R8 dav disabled");
    repeat (3) pop_chk("R4 order");
    // R11 empty pop
    pop_chk("R11 empty zero");
    chk_state("R11 after empty pop");
    // R9 overrun
    wr(0, EN | RES | OVE | (32'hFF << 4));
    for (int i = 0; i < 128; i++) push(20'(i * 7 + 3));
    chk("R12 ready low when full", {31'h0, s_ready}, 0);
    push(20'hFFFFF);
    chk_state("R9 overrun set");
    pop_chk("R9 head after drop");
    wr(1, 32'h1);
    chk_state("R9 cleared");
    // R10 flush
    wr(0, ctl | 32'h1);
    chk_state("R10 flushed");
    rd(0, v); chk("R10 flush bit self-clears", {31'h0, v[0]}, 0);
    // R4 random traffic
    wr(0, EN | RES | DRQ | DAV | OVE | (32'd20 << 4));
    for (int i = 0; i < 500; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5) push(20'($urandom));
      else if (op < 9) pop_chk("R4 random pop");
      else wr(0, (ctl & ~(RES | MODE)) | ($urandom_range(0, 1) ? RES : 0) | ($urandom_range(0, 1) ? MODE : 0));
      if (i % 10 == 0) chk_state("R4 random");
    end
    wr(0, ctl | 32'h1);
    // R3 start-up hold
    delay_run(2'd0, 5);
    delay_run(2'd1, 10);
    delay_run(2'd3, 30);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule